// File: doc/BRIEF.md
# Saturating-Counter Branch Direction Predictor

This block is an untagged table of saturating counters that the fetch stage reads with the instruction address to get a taken or not-taken hint. The lookup is combinational: the hint is valid in the same cycle the address is presented. Fetch follows the hint, and once the branch resolves, its address and its real outcome are sent back on the update port. The counter for that address then moves toward the outcome.

The table holds no tags. Every lookup returns a prediction, and two branches whose word addresses share the low index bits share one counter. The counter width is a parameter. At a width of 1, each entry is a single bit that flips on every wrong guess. Wider counters saturate at both ends, so a strongly biased branch survives one odd outcome with only one misprediction.

Top module: `branch_hint_table`

## Requirements
- R1: After reset, every counter holds the weakly not-taken value 2^(CTR_W-1)-1, which is 1 at the default width of 2 and 0 at width 1. Every lookup then predicts not taken, and one taken update of a width-2 entry makes it predict taken.
- R2: The entry index is address bits [IDX_W+1:2]. Bits [1:0] and bits above IDX_W+1 have no effect. Two addresses that agree in bits [IDX_W+1:2] read and train the same counter.
- R3: An update with the outcome taken increments the indexed counter. A counter at 2^CTR_W-1 stays there.
- R4: An update with the outcome not taken decrements the indexed counter. A counter at 0 stays there.
- R5: The hint is taken (predTaken = 1) exactly when the counter is at least 2^(CTR_W-1), which is its most significant bit.
- R6: At width 2, a counter at either extreme needs two consecutive opposite outcomes before its hint changes.
- R7: At width 1, one opposite outcome inverts the stored hint.
- R8: A lookup that meets an update to the same index in the same cycle returns the value from before the update. The change is visible from the next cycle.
- R9: While updValid is low, no counter changes, whatever updPc and updTaken carry.
- R10: The lookup is combinational: predTaken reflects the lookupPc presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lookupPc | input | PC_W | Fetch address to predict |
| predTaken | output | 1 | Hint: 1 = taken |
| updValid | input | 1 | Update strobe for a resolved branch |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome: 1 = taken |

## Verification
The assertions assume that updTaken is meaningful only while updValid is high. They also assume that the lookup address is held steady for a cycle whenever the hold property is expected to bite; a changing address is outside that property. The stimulus keeps both inputs at known values at all times after reset and changes them only away from the clock edge. The random phase draws addresses from a few colliding indices, so aliased entries, saturation and same-cycle read/update collisions all come up often.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef struct packed {
    logic incr;
    logic decr;
  } ctrStrobe_t;
endpackage

// File: rtl/bht_ctrl.sv
module bht_ctrl
  import bht_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic             updValid,
  input  logic             updTaken,
  input  logic [CTR_W-1:0] updCtr,
  output ctrStrobe_t       strb
);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  logic atTop;
  logic atBottom;

  assign atTop    = (updCtr == CTR_MAX);
  assign atBottom = (updCtr == CTR_MIN);

  always_comb begin
    strb      = '0;
    strb.incr = updValid &&  updTaken && !atTop;
    strb.decr = updValid && !updTaken && !atBottom;
  end
endmodule

// File: rtl/bht_datapath.sv
module bht_datapath
  import bht_pkg::*;
#(
  parameter int CTR_W = 2,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [IDX_W-1:0] wrIdx,
  input  ctrStrobe_t       strb,
  output logic [CTR_W-1:0] rdCtr,
  output logic [CTR_W-1:0] wrCtr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] RST_VAL = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] ctrQ [DEPTH];
  logic [DEPTH-1:0] entSel;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_sel
    assign entSel[gi] = (wrIdx == IDX_W'(gi));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ctrQ[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (entSel[i] && strb.incr)      ctrQ[i] <= ctrQ[i] + 1'b1;
        else if (entSel[i] && strb.decr) ctrQ[i] <= ctrQ[i] - 1'b1;
      end
    end
  end

  assign rdCtr = ctrQ[rdIdx];
  assign wrCtr = ctrQ[wrIdx];
endmodule

// File: rtl/branch_hint_table.sv
module branch_hint_table
  import bht_pkg::*;
#(
  parameter int CTR_W = 2,
  parameter int IDX_W = 6,
  parameter int PC_W  = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;

  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;
  logic [CTR_W-1:0] rdCtr;
  logic [CTR_W-1:0] updCtr;
  ctrStrobe_t       strb;

  assign rdIdx = lookupPc[IDX_HI:IDX_LO];
  assign wrIdx = updPc[IDX_HI:IDX_LO];

  bht_ctrl #(.CTR_W(CTR_W)) u_ctrl (
    .updValid(updValid),
    .updTaken(updTaken),
    .updCtr  (updCtr),
    .strb    (strb)
  );

  bht_datapath #(.CTR_W(CTR_W), .IDX_W(IDX_W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .rdIdx(rdIdx),
    .wrIdx(wrIdx),
    .strb (strb),
    .rdCtr(rdCtr),
    .wrCtr(updCtr)
  );

  assign predTaken = rdCtr[CTR_W-1];
endmodule

// File: rtl/branch_hint_table_chk.sv
module branch_hint_table_chk
  import bht_pkg::*;
#(
  parameter int CTR_W = 2,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [PC_W-1:0]  lookupPc,
  input logic             predTaken,
  input logic             updValid,
  input logic             updTaken,
  input logic [CTR_W-1:0] updCtr,
  input ctrStrobe_t       strb
);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  a_r3_incr_saturates: assert property (@(posedge clk) disable iff (!rstN)
    strb.incr |-> (updValid && updTaken && updCtr != CTR_MAX));

  a_r4_decr_saturates: assert property (@(posedge clk) disable iff (!rstN)
    strb.decr |-> (updValid && !updTaken && updCtr != '0));

  a_r3_single_move: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.incr, strb.decr}));

  a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !(strb.incr || strb.decr));

  a_r9_idle_hint_hold: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> ($stable(lookupPc) |-> $stable(predTaken)));
endmodule

bind branch_hint_table branch_hint_table_chk #(.CTR_W(CTR_W), .PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lookupPc (lookupPc),
  .predTaken(predTaken),
  .updValid (updValid),
  .updTaken (updTaken),
  .updCtr   (updCtr),
  .strb     (strb)
);

// File: tb/branch_hint_table_bench.sv
module branch_hint_table_bench;
  localparam int IDX_W = 6;
  localparam int PC_W  = 32;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic [PC_W-1:0] updPc = '0;
  logic updValid = 1'b0;
  logic updTaken = 1'b0;
  logic predW2, predW1;

  int vectors = 0;
  int miss = 0;
  int cycles = 0;
  int ref2 [DEPTH];
  int ref1 [DEPTH];

  always #5 clk = ~clk;

  branch_hint_table #(.CTR_W(2), .IDX_W(IDX_W), .PC_W(PC_W)) u_branch_hint_table (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predW2),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken));

  branch_hint_table #(.CTR_W(1), .IDX_W(IDX_W), .PC_W(PC_W)) u_branch_hint_table_w1 (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predW1),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken));

  function automatic int idxOf(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic int bump(input int v, input bit t, input int maxV);
    if (t) return (v < maxV) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  endtask

  task automatic step(input logic [PC_W-1:0] lpc, input bit uv,
                      input logic [PC_W-1:0] upc, input bit ut, input string tag);
    @(negedge clk);
    lookupPc = lpc; updValid = uv; updPc = upc; updTaken = ut;
    #1;
    check({tag, " w2"}, predW2, ref2[idxOf(lpc)] >= 2);
    check({tag, " w1"}, predW1, ref1[idxOf(lpc)] >= 1);
    if (uv) begin
      ref2[idxOf(upc)] = bump(ref2[idxOf(upc)], ut, 3);
      ref1[idxOf(upc)] = bump(ref1[idxOf(upc)], ut, 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        miss++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [PC_W-1:0] pcA, pcB, pcX;
    logic [PC_W-1:0] pool [4];
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < DEPTH; i++) begin ref2[i] = 1; ref1[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 R10: all entries weakly not taken after reset
    for (int i = 0; i < DEPTH; i++) step(PC_W'(i) << 2, 1'b0, '0, 1'b0, "R1 reset");

    // R8: same-cycle lookup sees the old value, the next cycle the new one
    pcX = 32'h0000_0014;
    step(pcX, 1'b1, pcX, 1'b1, "R8 same cycle");
    step(pcX, 1'b0, '0, 1'b0, "R1 R5 after one taken");

    // R3 then R6/R7: saturate up, then single miss
    repeat (5) step(pcX, 1'b1, pcX, 1'b1, "R3 saturate up");
    step(pcX, 1'b1, pcX, 1'b0, "R6 first miss");
    step(pcX, 1'b0, '0, 1'b0, "R6 R7 after one miss");
    step(pcX, 1'b1, pcX, 1'b0, "R6 second miss");
    step(pcX, 1'b0, '0, 1'b0, "R6 after two misses");

    // R4: saturate down, one taken keeps w2 not taken
    repeat (5) step(pcX, 1'b1, pcX, 1'b0, "R4 saturate down");
    step(pcX, 1'b1, pcX, 1'b1, "R4 one taken");
    step(pcX, 1'b0, '0, 1'b0, "R4 R7 after one taken");

    // R9: updValid low, other inputs active
    pcA = 32'h0000_0040;
    repeat (4) step(pcA, 1'b0, pcA, 1'b1, "R9 idle update");
    step(pcA, 1'b0, '0, 1'b0, "R9 unchanged");

    // R2: aliasing and ignored low/high bits
    pcB = pcA + (32'h1 << (IDX_W + 2));
    repeat (3) step(pcA + 32'd3, 1'b1, pcB + 32'd1, 1'b1, "R2 alias train");
    step(pcA, 1'b0, '0, 1'b0, "R2 alias read");
    step(pcA ^ 32'hFFFF_0000, 1'b0, '0, 1'b0, "R2 high bits");

    // R5: random traffic over colliding indices
    pool[0] = 32'h0000_0100; pool[1] = 32'h0000_0104;
    pool[2] = pool[0] + (32'h1 << (IDX_W + 2)); pool[3] = 32'h0000_00FC;
    for (int n = 0; n < 2000; n++) begin
      logic [PC_W-1:0] l, u;
      l = pool[$urandom_range(3)] | PC_W'($urandom_range(3));
      u = ($urandom_range(7) == 0) ? PC_W'($urandom) : pool[$urandom_range(3)];
      step(l, ($urandom_range(3) != 0), u, $urandom_range(1) == 1, "R5 random");
    end

    @(negedge clk);
    updValid = 1'b0;
    summary();
  end
endmodule